// File: doc/BRIEF.md
# Multi-Channel ADC Scan Sequencer

This block is the digital controller in front of a successive-approximation analog core. When it is started, it walks a contiguous range of analog inputs. For each input it drives a sampling strobe for a programmable number of conversion-clock cycles, then a conversion strobe for one cycle per result bit. It captures the result from the core, formats it into a 16-bit data word and stores the word in a per-channel data register. That register carries a done flag and an overwrite flag.

A scan can start from a software pulse, a timer underflow pulse or a falling edge on an active-low external trigger pin. A 2-bit select picks which of these is used. A scan runs once over the range, or repeats until a software stop arrives. The register decode, the pin muxing and the analog circuitry are outside this block. Configuration arrives as plain input levels, and results are read through a channel-indexed read port with a read strobe.

Top module: `adc_seq_ctrl`

## Requirements
- R1: With `cfg_left_just_i`=1 the 10-bit result occupies data bits 15:6 and bits 5:0 read zero. With 0 it occupies bits 9:0 and bits 15:10 read zero. The justification is applied when the result is stored.
- R2: Trigger select `cfg_trig_sel_i` encodes 0 = software pulse `sw_start_i`, 1 = timer pulse `tmr_uflow_i`, 3 = external pin `ext_trig_ni`. Code 2 never starts a scan. An unselected source has no effect.
- R3: The external pin passes through a two-flop synchronizer and then falling-edge detection. The scan begins (`busy_o` high, `ana_sample_o` high) after the third rising clock edge following the pin falling. A low level held on the pin starts exactly one scan.
- R4: For each channel, `ana_sample_o` is high for exactly (`cfg_samp_i` + 2) cycles. `ana_conv_o` follows in the very next cycle. The two strobes are never high together.
- R5: `ana_conv_o` stays high for exactly 10 cycles. The core result present in the last of those cycles is stored in the data register of the channel on `ana_ch_o`.
- R6: A scan visits channels in ascending order from `cfg_ch_first_i` to `cfg_ch_last_i`. If the last channel is below the first, only the first channel is converted.
- R7: With `cfg_cont_i`=0 the block returns to idle (`busy_o` low) right after the last channel. `busy_o` is high for exactly N·(`cfg_samp_i`+12) cycles, where N is the channel count.
- R8: With `cfg_cont_i`=1 the scan wraps from the last channel back to the first with no idle cycle in between, and keeps going.
- R9: A `sw_stop_i` pulse during a scan lets the channel in progress finish its conversion and store its result. The block then goes idle without sampling another channel. A stop pulse while idle has no effect on the next scan.
- R10: Start pulses that arrive while a scan is in progress are ignored: the scan length is unchanged and no new scan follows.
- R11: Storing a result sets that channel's bit in `done_o`. `rd_data_o` shows the word of channel `rd_ch_i`. A one-cycle `rd_en_i` clears that channel's done and overwrite bits.
- R12: If a result is stored while the channel's done bit is still set and not being read in the same cycle, that channel's `ovr_o` bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Conversion clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_left_just_i | input | 1 | 1 = left-justified result, 0 = right-justified |
| cfg_cont_i | input | 1 | 1 = repeat scan, 0 = single scan |
| cfg_trig_sel_i | input | 2 | Start source select |
| cfg_samp_i | input | 3 | Sampling length minus two, in cycles |
| cfg_ch_first_i | input | 3 | First channel of the scan |
| cfg_ch_last_i | input | 3 | Last channel of the scan |
| sw_start_i | input | 1 | Software start pulse |
| sw_stop_i | input | 1 | Software stop pulse |
| tmr_uflow_i | input | 1 | Timer underflow pulse |
| ext_trig_ni | input | 1 | External trigger pin, active low, asynchronous |
| ana_result_i | input | 10 | Result from the analog core |
| ana_sample_o | output | 1 | Sampling strobe to the analog core |
| ana_conv_o | output | 1 | Conversion strobe to the analog core |
| ana_ch_o | output | 3 | Selected analog input |
| busy_o | output | 1 | Scan in progress |
| rd_ch_i | input | 3 | Channel whose data word is read |
| rd_en_i | input | 1 | Read strobe, clears the flags of `rd_ch_i` |
| rd_data_o | output | 16 | Data word of `rd_ch_i` |
| done_o | output | 8 | Per-channel result-ready flags |
| ovr_o | output | 8 | Per-channel overwrite flags |

## Verification
The bench builds the block with its default parameters: 3-bit channel fields (8 channels), a 10-bit result and a 3-bit sampling field. At that size all 64 first/last channel pairs can be swept, covering reversed and single-channel ranges. Across the sweep every sampling setting and both justifications are exercised. Each data word is predicted from a channel-dependent formula for the core model's output. The remaining scenarios exercise every trigger code, a held external level, continuous wrap with a mid-conversion stop, and unread overwrites.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [1:0] {
    TRG_SW   = 2'd0,
    TRG_TMR  = 2'd1,
    TRG_RSVD = 2'd2,
    TRG_EXT  = 2'd3
  } trig_sel_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SAMP = 2'd1,
    ST_CONV = 2'd2
  } seq_state_e;
endpackage

// File: rtl/adc_trig_unit.sv
module adc_trig_unit
  import adc_seq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] sel_i,
  input  logic       sw_start_i,
  input  logic       tmr_uflow_i,
  input  logic       ext_trig_ni,
  output logic       start_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   ext_lvl;
  logic                   ext_fall;

  assign ext_lvl  = sync_q[SYNC_STAGES-1];
  assign ext_fall = prev_q & ~ext_lvl;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '1;
      prev_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], ext_trig_ni};
      prev_q <= ext_lvl;
    end
  end

  always_comb begin
    unique case (trig_sel_e'(sel_i))
      TRG_SW:  start_o = sw_start_i;
      TRG_TMR: start_o = tmr_uflow_i;
      TRG_EXT: start_o = ext_fall;
      default: start_o = 1'b0;
    endcase
  end

  AST_EXT_SINGLE_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_fall |=> !ext_fall); // R3
  AST_RSVD_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == 2'd2) |-> !start_o); // R2
endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
  import adc_seq_pkg::*;
#(
  parameter int CH_W     = 3,
  parameter int SAMP_W   = 3,
  parameter int CONV_CYC = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              cont_i,
  input  logic [SAMP_W-1:0] samp_i,
  input  logic [CH_W-1:0]   first_i,
  input  logic [CH_W-1:0]   last_i,
  output logic              sample_o,
  output logic              conv_o,
  output logic [CH_W-1:0]   ch_o,
  output logic              busy_o,
  output logic              wr_en_o
);
  localparam int CONV_W = $clog2(CONV_CYC);
  localparam int CNT_W  = (CONV_W > SAMP_W + 1) ? CONV_W : SAMP_W + 1;

  seq_state_e        state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [CH_W-1:0]   ch_q, first_q, last_q;
  logic [SAMP_W-1:0] samp_q;
  logic              stop_q;
  logic              at_end;

  assign at_end   = (ch_q == last_q);
  assign sample_o = (state_q == ST_SAMP);
  assign conv_o   = (state_q == ST_CONV);
  assign busy_o   = (state_q != ST_IDLE);
  assign ch_o     = ch_q;
  assign wr_en_o  = conv_o && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      ch_q    <= '0;
      first_q <= '0;
      last_q  <= '0;
      samp_q  <= '0;
      stop_q  <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          stop_q <= 1'b0;
          if (start_i) begin
            state_q <= ST_SAMP;
            ch_q    <= first_i;
            first_q <= first_i;
            last_q  <= (last_i < first_i) ? first_i : last_i;
            samp_q  <= samp_i;
            cnt_q   <= CNT_W'(samp_i) + CNT_W'(1);
          end
        end
        ST_SAMP: begin
          if (stop_i) stop_q <= 1'b1;
          if (cnt_q == '0) begin
            state_q <= ST_CONV;
            cnt_q   <= CNT_W'(CONV_CYC - 1);
          end else begin
            cnt_q <= cnt_q - CNT_W'(1);
          end
        end
        ST_CONV: begin
          if (stop_i) stop_q <= 1'b1;
          if (cnt_q != '0) begin
            cnt_q <= cnt_q - CNT_W'(1);
          end else if (stop_q || stop_i) begin
            state_q <= ST_IDLE;
          end else if (at_end) begin
            if (cont_i) begin
              state_q <= ST_SAMP;
              ch_q    <= first_q;
              cnt_q   <= CNT_W'(samp_q) + CNT_W'(1);
            end else begin
              state_q <= ST_IDLE;
            end
          end else begin
            state_q <= ST_SAMP;
            ch_q    <= ch_q + CH_W'(1);
            cnt_q   <= CNT_W'(samp_q) + CNT_W'(1);
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // run-length counter for the conversion window check
  logic [CNT_W-1:0] conv_run_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     conv_run_q <= '0;
    else if (conv_o) conv_run_q <= conv_run_q + CNT_W'(1);
    else             conv_run_q <= '0;
  end

  AST_STROBE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sample_o && conv_o)); // R4
  AST_SAMP_TO_CONV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sample_o) |-> conv_o); // R4
  AST_CONV_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(conv_o) |-> $past(conv_run_q) == CNT_W'(CONV_CYC - 1)); // R5
  AST_SCAN_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> (ch_o == $past(first_i)) && sample_o); // R6
  AST_STOP_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o && stop_q) |=> !busy_o); // R9
  AST_BUSY_IGNORES_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_o && start_i) |=> (ch_o == $past(ch_o))); // R10
endmodule

// File: rtl/adc_result_bank.sv
module adc_result_bank #(
  parameter int CH_W   = 3,
  parameter int RES_W  = 10,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              left_i,
  input  logic              wr_en_i,
  input  logic [CH_W-1:0]   wr_ch_i,
  input  logic [RES_W-1:0]  wr_res_i,
  input  logic              rd_en_i,
  input  logic [CH_W-1:0]   rd_ch_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [(1<<CH_W)-1:0] done_o,
  output logic [(1<<CH_W)-1:0] ovr_o
);
  localparam int NCH = 1 << CH_W;
  localparam int PAD = DATA_W - RES_W;

  logic [DATA_W-1:0]           word;
  logic [NCH-1:0][DATA_W-1:0]  data_all;

  assign word = left_i ? {wr_res_i, {PAD{1'b0}}} : {{PAD{1'b0}}, wr_res_i};

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic              hit_wr, hit_rd;
    logic [DATA_W-1:0] data_q;
    logic              done_q, ovr_q;

    assign hit_wr = wr_en_i && (wr_ch_i == CH_W'(g));
    assign hit_rd = rd_en_i && (rd_ch_i == CH_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        data_q <= '0;
        done_q <= 1'b0;
        ovr_q  <= 1'b0;
      end else if (hit_wr) begin
        data_q <= word;
        done_q <= 1'b1;
        ovr_q  <= (ovr_q | done_q) & ~hit_rd;
      end else if (hit_rd) begin
        done_q <= 1'b0;
        ovr_q  <= 1'b0;
      end
    end

    assign data_all[g] = data_q;
    assign done_o[g]   = done_q;
    assign ovr_o[g]    = ovr_q;
  end

  assign rd_data_o = data_all[rd_ch_i];

  AST_DONE_ON_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> done_o[$past(wr_ch_i)]); // R11
  AST_OVR_ON_UNREAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && done_o[wr_ch_i] && !(rd_en_i && rd_ch_i == wr_ch_i))
      |=> ovr_o[$past(wr_ch_i)]); // R12
  AST_READ_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && !(wr_en_i && wr_ch_i == rd_ch_i))
      |=> !done_o[$past(rd_ch_i)] && !ovr_o[$past(rd_ch_i)]); // R11
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl #(
  parameter int CH_W        = 3,
  parameter int SAMP_W      = 3,
  parameter int RES_W       = 10,
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cfg_left_just_i,
  input  logic                 cfg_cont_i,
  input  logic [1:0]           cfg_trig_sel_i,
  input  logic [SAMP_W-1:0]    cfg_samp_i,
  input  logic [CH_W-1:0]      cfg_ch_first_i,
  input  logic [CH_W-1:0]      cfg_ch_last_i,
  input  logic                 sw_start_i,
  input  logic                 sw_stop_i,
  input  logic                 tmr_uflow_i,
  input  logic                 ext_trig_ni,
  input  logic [RES_W-1:0]     ana_result_i,
  output logic                 ana_sample_o,
  output logic                 ana_conv_o,
  output logic [CH_W-1:0]      ana_ch_o,
  output logic                 busy_o,
  input  logic [CH_W-1:0]      rd_ch_i,
  input  logic                 rd_en_i,
  output logic [DATA_W-1:0]    rd_data_o,
  output logic [(1<<CH_W)-1:0] done_o,
  output logic [(1<<CH_W)-1:0] ovr_o
);
  logic start;
  logic wr_en;

  adc_trig_unit #(.SYNC_STAGES(SYNC_STAGES)) u_trig (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sel_i       (cfg_trig_sel_i),
    .sw_start_i  (sw_start_i),
    .tmr_uflow_i (tmr_uflow_i),
    .ext_trig_ni (ext_trig_ni),
    .start_o     (start)
  );

  adc_seq_fsm #(.CH_W(CH_W), .SAMP_W(SAMP_W), .CONV_CYC(RES_W)) u_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start),
    .stop_i   (sw_stop_i),
    .cont_i   (cfg_cont_i),
    .samp_i   (cfg_samp_i),
    .first_i  (cfg_ch_first_i),
    .last_i   (cfg_ch_last_i),
    .sample_o (ana_sample_o),
    .conv_o   (ana_conv_o),
    .ch_o     (ana_ch_o),
    .busy_o   (busy_o),
    .wr_en_o  (wr_en)
  );

  adc_result_bank #(.CH_W(CH_W), .RES_W(RES_W), .DATA_W(DATA_W)) u_bank (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .left_i    (cfg_left_just_i),
    .wr_en_i   (wr_en),
    .wr_ch_i   (ana_ch_o),
    .wr_res_i  (ana_result_i),
    .rd_en_i   (rd_en_i),
    .rd_ch_i   (rd_ch_i),
    .rd_data_o (rd_data_o),
    .done_o    (done_o),
    .ovr_o     (ovr_o)
  );
endmodule

// File: tb/tb_adc_seq_ctrl.sv
module tb_adc_seq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        left = 1'b0, cont = 1'b0;
  logic [1:0]  tsel = 2'd0;
  logic [2:0]  samp = 3'd7, first = 3'd0, last = 3'd0;
  logic        sw_start = 1'b0, sw_stop = 1'b0, tmr = 1'b0, ext_n = 1'b1;
  logic [9:0]  ana_res;
  logic        sample, conv, busy;
  logic [2:0]  ana_ch;
  logic [2:0]  rd_ch = 3'd0;
  logic        rd_en = 1'b0;
  logic [15:0] rd_data;
  logic [7:0]  done, ovr;

  int errs = 0, checks = 0;
  int seed = 0;
  int exp_samp = 0;
  int seq[64];
  int seq_n = 0, busy_cyc = 0;
  int samp_len = 0, conv_len = 0;
  bit prev_s = 0, prev_c = 0;
  int prev_ch = 0;

  always #2 clk = ~clk;

  assign ana_res = 10'((seed * 16 + int'(ana_ch) * 73 + 5) % 1024);

  adc_seq_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_left_just_i(left), .cfg_cont_i(cont),
    .cfg_trig_sel_i(tsel), .cfg_samp_i(samp), .cfg_ch_first_i(first),
    .cfg_ch_last_i(last), .sw_start_i(sw_start), .sw_stop_i(sw_stop),
    .tmr_uflow_i(tmr), .ext_trig_ni(ext_n), .ana_result_i(ana_res),
    .ana_sample_o(sample), .ana_conv_o(conv), .ana_ch_o(ana_ch), .busy_o(busy),
    .rd_ch_i(rd_ch), .rd_en_i(rd_en), .rd_data_o(rd_data), .done_o(done), .ovr_o(ovr)
  );

  task automatic chk(bit ok, string req, string what, int act, int expv);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  function automatic logic [15:0] exp_word(int ch, int s, bit lj);
    int r = (s * 16 + ch * 73 + 5) % 1024;
    return lj ? 16'(r << 6) : 16'(r);
  endfunction

  // strobe monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (sample && conv) chk(0, "R4", "strobes overlap", 1, 0);
      if (busy) busy_cyc++;
      if (sample) begin
        if (!prev_s) samp_len = 0;
        samp_len++;
      end
      if (prev_s && !sample) begin
        chk(conv, "R4", "conv follows sample", int'(conv), 1);
        chk(samp_len == exp_samp + 2, "R4", "sample width", samp_len, exp_samp + 2);
        if (seq_n < 64) seq[seq_n] = prev_ch;
        seq_n++;
      end
      if (conv) begin
        if (!prev_c) conv_len = 0;
        conv_len++;
      end
      if (prev_c && !conv) chk(conv_len == 10, "R5", "conv width", conv_len, 10);
      prev_s = sample;
      prev_c = conv;
      prev_ch = int'(ana_ch);
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_sw();
    @(negedge clk) sw_start = 1'b1;
    @(negedge clk) sw_start = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 5000 && busy; i++) @(negedge clk);
  endtask

  task automatic clear_mon();
    seq_n = 0;
    busy_cyc = 0;
  endtask

  task automatic read_ch(int ch);
    @(negedge clk) rd_ch = 3'(ch);
    rd_en = 1'b1;
    @(negedge clk) rd_en = 1'b0;
  endtask

  task automatic clear_all();
    for (int c = 0; c < 8; c++) read_ch(c);
  endtask

  task automatic scan(int f, int l, int s, bit lj, int sd, bit do_read);
    int n;
    first = 3'(f); last = 3'(l); samp = 3'(s); left = lj; seed = sd; exp_samp = s;
    n = (l >= f) ? l - f + 1 : 1;
    clear_mon();
    pulse_sw();
    wait_idle();
    chk(seq_n == n, "R7", "channel count", seq_n, n);
    for (int i = 0; i < n && i < seq_n; i++)
      chk(seq[i] == f + i, "R6", "channel order", seq[i], f + i);
    chk(busy_cyc == n * (s + 12), "R7", "busy length", busy_cyc, n * (s + 12));
    if (do_read) begin
      for (int c = 0; c < 8; c++) begin
        bit in_r = (c >= f && c <= f + n - 1);
        @(negedge clk) rd_ch = 3'(c);
        #0.5;
        chk(done[c] == in_r, "R11", "done flag", int'(done[c]), int'(in_r));
        if (in_r)
          chk(rd_data == exp_word(c, sd, lj), lj ? "R1" : "R5", "data word",
              int'(rd_data), int'(exp_word(c, sd, lj)));
        rd_en = 1'b1;
        @(negedge clk) rd_en = 1'b0;
        chk(done[c] == 1'b0 && ovr[c] == 1'b0, "R11", "read clears flags",
            int'({done[c], ovr[c]}), 0);
      end
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errs++;
    checks++;
    $display("FAIL watchdog expired: actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    cyc(3);
    #1 rst_n = 1'b1;
    cyc(1);
    chk(!busy && !sample && !conv, "R7", "reset idle", int'({busy, sample, conv}), 0);
    chk(done == 8'h0 && ovr == 8'h0, "R11", "reset flags", int'({done, ovr}), 0);
    chk(rd_data == 16'h0, "R11", "reset data", int'(rd_data), 0);

    // R6 R1 R4: sweep every first/last pair, rotating sampling and justification
    for (int f = 0; f < 8; f++)
      for (int l = 0; l < 8; l++)
        scan(f, l, (f * 3 + l) % 8, 1'((f + l) & 1), f * 8 + l, 1'b1);

    // R12 overwrite of an unread result
    scan(2, 2, 1, 1'b0, 90, 1'b0);
    chk(ovr == 8'h0 && done == 8'h04, "R12", "first write no ovr", int'({done, ovr}), 32'h0400);
    scan(2, 2, 1, 1'b0, 91, 1'b0);
    chk(ovr == 8'h04 && done == 8'h04, "R12", "second write sets ovr", int'({done, ovr}), 32'h0404);
    @(negedge clk) rd_ch = 3'd2;
    #0.5 chk(rd_data == exp_word(2, 91, 1'b0), "R12", "newest data kept", int'(rd_data),
             int'(exp_word(2, 91, 1'b0)));
    read_ch(2);
    chk(ovr == 8'h0 && done == 8'h0, "R11", "read clears ovr", int'({done, ovr}), 0);

    // R8 R9 continuous wrap then stop mid-conversion
    cont = 1'b1; first = 3'd5; last = 3'd7; samp = 3'd0; exp_samp = 0; seed = 7;
    clear_mon();
    pulse_sw();
    for (int i = 0; i < 2000 && seq_n < 7; i++) @(negedge clk);
    sw_stop = 1'b1;
    @(negedge clk) sw_stop = 1'b0;
    wait_idle();
    cont = 1'b0;
    chk(seq_n == 7, "R9", "channels after stop", seq_n, 7);
    for (int i = 0; i < 7; i++)
      chk(seq[i] == 5 + (i % 3), "R8", "wrap order", seq[i], 5 + (i % 3));
    chk(busy_cyc == 7 * 12, "R8", "no gap on wrap", busy_cyc, 84);
    @(negedge clk) rd_ch = 3'd5;
    #0.5 chk(done[5] && rd_data == exp_word(5, 7, 1'b0), "R9", "stopped channel stored",
             int'(rd_data), int'(exp_word(5, 7, 1'b0)));
    cyc(40);
    chk(!busy, "R9", "stays idle after stop", int'(busy), 0);
    clear_all();

    // R9 stop while idle has no effect
    @(negedge clk) sw_stop = 1'b1;
    @(negedge clk) sw_stop = 1'b0;
    scan(1, 3, 2, 1'b1, 33, 1'b1);

    // R10 start during scan ignored
    first = 3'd0; last = 3'd1; samp = 3'd0; exp_samp = 0;
    clear_mon();
    pulse_sw();
    cyc(5);
    pulse_sw();
    cyc(14);
    pulse_sw();
    wait_idle();
    chk(seq_n == 2 && busy_cyc == 24, "R10", "scan length unchanged", busy_cyc, 24);
    cyc(20);
    chk(!busy && seq_n == 2, "R10", "no follow-on scan", seq_n, 2);
    clear_all();

    // R2 source selection
    first = 3'd3; last = 3'd3; samp = 3'd0; exp_samp = 0;
    @(negedge clk) tmr = 1'b1;
    @(negedge clk) tmr = 1'b0;
    ext_n = 1'b0;
    cyc(8);
    chk(!busy, "R2", "sel 0 ignores timer and pin", int'(busy), 0);
    ext_n = 1'b1;
    cyc(4);
    tsel = 2'd1;
    pulse_sw();
    cyc(3);
    chk(!busy, "R2", "sel 1 ignores software", int'(busy), 0);
    @(negedge clk) tmr = 1'b1;
    @(negedge clk) tmr = 1'b0;
    chk(busy, "R2", "sel 1 timer starts", int'(busy), 1);
    wait_idle();
    tsel = 2'd2;
    pulse_sw();
    @(negedge clk) tmr = 1'b1;
    @(negedge clk) tmr = 1'b0;
    ext_n = 1'b0;
    cyc(8);
    chk(!busy, "R2", "reserved code never starts", int'(busy), 0);
    ext_n = 1'b1;
    cyc(4);

    // R3 external falling edge through synchronizer
    tsel = 2'd3;
    pulse_sw();
    cyc(3);
    chk(!busy, "R3", "sel 3 ignores software", int'(busy), 0);
    ext_n = 1'b0;
    @(negedge clk) chk(!busy, "R3", "latency edge 1", int'(busy), 0);
    @(negedge clk) chk(!busy, "R3", "latency edge 2", int'(busy), 0);
    @(negedge clk) chk(busy && sample, "R3", "start on edge 3", int'({busy, sample}), 3);
    wait_idle();
    cyc(40);
    chk(!busy, "R3", "held low starts once", int'(busy), 0);
    ext_n = 1'b1;
    cyc(5);
    ext_n = 1'b0;
    cyc(4);
    chk(busy, "R3", "new edge starts again", int'(busy), 1);
    wait_idle();
    ext_n = 1'b1;
    tsel = 2'd0;
    clear_all();

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule